// File: doc/BRIEF.md
# Sleep-Cleared Weighted Threshold Gate

This block is a clocked behavioural model of one threshold gate from a dual-rail, delay-insensitive datapath. Each rail input carries a weight. When the gate is awake and the weights of the asserted inputs add up to at least the threshold, the output goes high. The gate has no hysteresis path, so the inputs falling back to zero never clear the output. Only the sleep input drives it back to zero, which models the spacer (NULL) phase of the datapath. The model takes one evaluation step per rising clock edge.

The number of inputs, the threshold, the weight field width and the per-input weights are all parameters. When every weight is one, the gate is the plain count-of-ones form; otherwise it uses a weighted adder chain. Elaboration stops if the threshold lies outside 1 to the total weight, if any weight is zero, or if the input count is below 1.

Top module: `thr_sleep_gate`

## Requirements
- R1: While `rst_n` is low, `th_out` is 0.
- R2: If `sleep` is 1 at a rising edge, `th_out` is 0 after that edge, whatever `rail_in` holds.
- R3: If `sleep` is 0 at a rising edge and the weighted sum of `rail_in` is at least `THRESH`, `th_out` is 1 after that edge.
- R4: If `th_out` is 0, `sleep` is 0 and the weighted sum is below `THRESH` at a rising edge, `th_out` stays 0 after that edge.
- R5: Once `th_out` is 1, it stays 1 at every edge where `sleep` is 0, even if all of `rail_in` returns to 0.
- R6: The weighted sum adds the weight field at `WEIGHTS[i*WGT_W +: WGT_W]` for each asserted `rail_in[i]`, so bit 0 of `rail_in` uses the lowest field.
- R7: At an edge where `sleep` is 1 and the threshold is also met, `sleep` wins and `th_out` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation step clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Forces the output to NULL (0) at the next edge |
| rail_in | input | N_IN | One rail bit per gate input |
| th_out | output | 1 | Registered gate output |

## Verification
Every result appears exactly one rising edge after the sleep level and rail pattern that cause it, because a single register sits between the inputs and `th_out`. The bench changes the inputs on the falling edge and compares outputs on the following falling edge, so each comparison sees the value produced by exactly one evaluation step. The hold check drives zeros for one step after a set and then samples. The sleep-priority check raises `sleep` in the same step as a pattern that meets the threshold.

// File: rtl/tg_pkg.sv
package tg_pkg;

   typedef enum logic {SUM_UNIT = 1'b0, SUM_WEIGHTED = 1'b1} sum_kind_e;

   localparam int unsigned MAX_WVEC = 1024;

   function automatic int unsigned field_at(input logic [MAX_WVEC-1:0] wv,
                                            input int unsigned idx,
                                            input int unsigned ww);
      logic [MAX_WVEC-1:0] mask;
      mask = (MAX_WVEC'(1) << ww) - MAX_WVEC'(1);
      return int'(32'((wv >> (idx * ww)) & mask));
   endfunction

   function automatic int unsigned weight_total(input logic [MAX_WVEC-1:0] wv,
                                                input int unsigned n,
                                                input int unsigned ww);
      int unsigned acc;
      acc = 0;
      for (int unsigned i = 0; i < n; i++) acc += field_at(wv, i, ww);
      return acc;
   endfunction

   function automatic int unsigned min_weight(input logic [MAX_WVEC-1:0] wv,
                                              input int unsigned n,
                                              input int unsigned ww);
      int unsigned lo;
      lo = field_at(wv, 0, ww);
      for (int unsigned i = 1; i < n; i++)
         if (field_at(wv, i, ww) < lo) lo = field_at(wv, i, ww);
      return lo;
   endfunction

   function automatic sum_kind_e pick_kind(input logic [MAX_WVEC-1:0] wv,
                                           input int unsigned n,
                                           input int unsigned ww);
      for (int unsigned i = 0; i < n; i++)
         if (field_at(wv, i, ww) != 1) return SUM_WEIGHTED;
      return SUM_UNIT;
   endfunction

endpackage

// File: rtl/tg_weight_sum.sv
module tg_weight_sum #(
   parameter int unsigned N_IN  = 3,
   parameter int unsigned WGT_W = 4,
   parameter logic [N_IN*WGT_W-1:0] WEIGHTS = {N_IN{WGT_W'(1)}},
   parameter int unsigned SUM_W = 2,
   parameter tg_pkg::sum_kind_e KIND = tg_pkg::SUM_UNIT
) (
   input  logic [N_IN-1:0]  rail_in,
   output logic [SUM_W-1:0] wsum
);
   generate
      if (KIND == tg_pkg::SUM_UNIT) begin : g_unit
         logic [SUM_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < int'(N_IN); i++) acc = acc + SUM_W'(rail_in[i]);
         end
         assign wsum = acc;
      end else begin : g_weighted
         logic [SUM_W-1:0] part [N_IN+1];
         assign part[0] = '0;
         for (genvar g = 0; g < int'(N_IN); g++) begin : g_term
            localparam logic [WGT_W-1:0] W_G = WEIGHTS[g*WGT_W +: WGT_W];
            assign part[g+1] = part[g] + (rail_in[g] ? SUM_W'(W_G) : '0);
         end
         assign wsum = part[N_IN];
      end
   endgenerate
endmodule

// File: rtl/tg_threshold_cmp.sv
module tg_threshold_cmp #(
   parameter int unsigned SUM_W  = 2,
   parameter int unsigned THRESH = 2
) (
   input  logic [SUM_W-1:0] wsum,
   output logic             set_hit
);
   localparam logic [SUM_W-1:0] THR_V = SUM_W'(THRESH);
   assign set_hit = (wsum >= THR_V);
endmodule

// File: rtl/tg_sleep_latch.sv
module tg_sleep_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic set_hit,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (sleep)   q <= 1'b0;
      else if (set_hit) q <= 1'b1;
   end
endmodule

// File: rtl/thr_sleep_gate.sv
module thr_sleep_gate #(
   parameter int unsigned N_IN   = 3,
   parameter int unsigned THRESH = 2,
   parameter int unsigned WGT_W  = 4,
   parameter logic [N_IN*WGT_W-1:0] WEIGHTS = {N_IN{WGT_W'(1)}}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep,
   input  logic [N_IN-1:0] rail_in,
   output logic            th_out
);
   localparam logic [tg_pkg::MAX_WVEC-1:0] WVEC = tg_pkg::MAX_WVEC'(WEIGHTS);
   localparam int unsigned TOTAL = tg_pkg::weight_total(WVEC, N_IN, WGT_W);
   localparam int unsigned LOW_W = tg_pkg::min_weight(WVEC, N_IN, WGT_W);
   localparam int unsigned SUM_W = (TOTAL < 2) ? 1 : $clog2(TOTAL + 1);
   localparam tg_pkg::sum_kind_e KIND = tg_pkg::pick_kind(WVEC, N_IN, WGT_W);

   generate
      if (N_IN < 1 || N_IN * WGT_W > tg_pkg::MAX_WVEC) begin : g_bad_shape
         $error("thr_sleep_gate: input count or weight vector size out of range");
      end
      if (LOW_W < 1) begin : g_bad_weight
         $error("thr_sleep_gate: every weight must be at least 1");
      end
      if (THRESH < 1 || THRESH > TOTAL) begin : g_bad_thresh
         $error("thr_sleep_gate: threshold must lie in 1..total weight");
      end
   endgenerate

   logic [SUM_W-1:0] wsum;
   logic             set_hit;

   tg_weight_sum #(
      .N_IN(N_IN), .WGT_W(WGT_W), .WEIGHTS(WEIGHTS), .SUM_W(SUM_W), .KIND(KIND)
   ) u_sum (
      .rail_in(rail_in),
      .wsum(wsum)
   );

   tg_threshold_cmp #(.SUM_W(SUM_W), .THRESH(THRESH)) u_cmp (
      .wsum(wsum),
      .set_hit(set_hit)
   );

   tg_sleep_latch u_state (
      .clk(clk),
      .rst_n(rst_n),
      .sleep(sleep),
      .set_hit(set_hit),
      .q(th_out)
   );
endmodule

// File: rtl/tg_checker.sv
module tg_checker (
   input logic clk,
   input logic rst_n,
   input logic sleep,
   input logic set_hit,
   input logic th_out
);
   p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !th_out);

   p_sleep_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !th_out);

   p_set_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && set_hit) |=> th_out);

   p_below_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!th_out && !sleep && !set_hit) |=> !th_out);

   p_hold_awake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (th_out && !sleep) |=> th_out);

   p_sleep_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && set_hit) |=> !th_out);
endmodule

bind thr_sleep_gate tg_checker u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .sleep(sleep),
   .set_hit(set_hit),
   .th_out(th_out)
);

// File: tb/thr_sleep_gate_tb.sv
module thr_sleep_gate_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep = 1'b0;
   logic [2:0] stim = 3'b000;
   logic [4:0] outs;
   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   // cfg 0: 2 in, m=1; cfg 1: 2 in, m=2; cfg 2: 3 in, m=2; cfg 3: 3 in, m=3;
   // cfg 4: 3 in, m=2, weight 2 on rail bit 0
   thr_sleep_gate #(.N_IN(2), .THRESH(1)) u_th12 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rail_in(stim[1:0]), .th_out(outs[0]));
   thr_sleep_gate #(.N_IN(2), .THRESH(2)) u_th22 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rail_in(stim[1:0]), .th_out(outs[1]));
   thr_sleep_gate #(.N_IN(3), .THRESH(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rail_in(stim), .th_out(outs[2]));
   thr_sleep_gate #(.N_IN(3), .THRESH(3)) u_th33 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rail_in(stim), .th_out(outs[3]));
   thr_sleep_gate #(.N_IN(3), .THRESH(2), .WGT_W(4), .WEIGHTS({4'd1, 4'd1, 4'd2})) u_th23w2 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rail_in(stim), .th_out(outs[4]));

   function automatic bit ref_set(input int cfg, input logic [2:0] x);
      int s;
      int m;
      case (cfg)
         0: begin s = x[0] + x[1]; m = 1; end
         1: begin s = x[0] + x[1]; m = 2; end
         2: begin s = x[0] + x[1] + x[2]; m = 2; end
         3: begin s = x[0] + x[1] + x[2]; m = 3; end
         default: begin s = 2 * x[0] + x[1] + x[2]; m = 2; end
      endcase
      return s >= m;
   endfunction

   task automatic check(input string req, input int cfg, input logic [2:0] x,
                        input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s cfg=%0d rail=%b actual=%b expected=%b", req, cfg, x, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
         summary();
      end
   end

   initial begin
      step();
      step();
      for (int c = 0; c < 5; c++) check("R1", c, stim, outs[c], 1'b0);
      rst_n = 1'b1;
      step();
      for (int c = 0; c < 5; c++) check("R4", c, stim, outs[c], 1'b0);

      for (int v = 0; v < 8; v++) begin
         logic [2:0] x;
         x = 3'(v);
         sleep = 1'b1; stim = x;
         step();
         for (int c = 0; c < 5; c++) check("R2", c, x, outs[c], 1'b0);
         sleep = 1'b0;
         step();
         for (int c = 0; c < 5; c++)
            check(c == 4 ? "R6" : (ref_set(c, x) ? "R3" : "R4"), c, x, outs[c], ref_set(c, x));
         stim = 3'b000;
         step();
         for (int c = 0; c < 5; c++)
            check(ref_set(c, x) ? "R5" : "R4", c, 3'b000, outs[c], ref_set(c, x));
         sleep = 1'b1; stim = x;
         step();
         for (int c = 0; c < 5; c++) check("R7", c, x, outs[c], 1'b0);
      end

      // TH23: one asserted rail is not enough, a second one sets the gate
      sleep = 1'b0; stim = 3'b100;
      step();
      check("R4", 2, stim, outs[2], 1'b0);
      check("R6", 4, stim, outs[4], 1'b0);
      stim = 3'b110;
      step();
      check("R3", 2, stim, outs[2], 1'b1);
      stim = 3'b000;
      step();
      check("R5", 2, stim, outs[2], 1'b1);
      sleep = 1'b1;
      step();
      check("R2", 2, stim, outs[2], 1'b0);

      done = 1;
      summary();
   end
endmodule